// File: doc/BRIEF.md
# Master/Slave Segment Output Selector

This block is the last digital stage in front of a multiplexed fluorescent-display driver. Three 56-bit segment latches hold the pattern for each of up to three grid phases. The block chooses one latch per phase and gates it with a brightness pulse. The result is a registered 56-bit segment word, plus the active-low grid enables for a tube wired to this device.

The mode pin picks the source of the phase and brightness information. With the pin high (master) the source is the internal timing generator. The block then drives the grids itself and forwards the phase code and brightness pulse on its sync and dim outputs, so that a second device can follow. With the pin low (slave), the phase comes from two external sync inputs and the brightness pulse from an external dim input, both driven by a master device. In slave mode the grid enables are forced inactive (high), and the forwarded sync and dim outputs are held low.

One 2-bit phase code is used on both sides. Code 1 selects latch 1, code 2 selects latch 2, code 3 selects latch 3, and code 0 selects nothing. On the external pins the code is formed with sync input 1 as bit 0 and sync input 2 as bit 1. The same mapping applies to the forwarded sync outputs.

Top module: `seg_out_select`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every segment output is low, every grid enable (`grid_n`) is high, and `dim_out`, `sync_out1` and `sync_out2` are low.
- R2: In master mode, each segment output equals the matching bit of the latch named by `tg_grid` (1, 2 or 3), ANDed with `tg_dim`.
- R3: In master mode, `sync_in1`, `sync_in2` and `dim_in` have no effect on any output.
- R4: In master mode, `grid_n` bit k (bit 0 = grid 1) is low exactly when `tg_grid` equals k+1 and `tg_dim` is high; at most one grid enable is ever low.
- R5: In master mode, `dim_out` equals `tg_dim`, `sync_out1` equals `tg_grid` bit 0, and `sync_out2` equals `tg_grid` bit 1.
- R6: In slave mode, the pair (`sync_in1`, `sync_in2`) selects the latch: (1,0) selects latch 1, (0,1) selects latch 2, (1,1) selects latch 3, and the selected latch reaches the segments while `dim_in` is high; `tg_grid` and `tg_dim` have no effect.
- R7: In slave mode, `dim_in` low drives all segment outputs low.
- R8: In slave mode, all `grid_n` bits are high and `dim_out`, `sync_out1`, `sync_out2` are low.
- R9: When the active phase code is 0 (no latch selected), all segment outputs are low, in either mode.
- R10: Every output is registered: a change on a latch bus, phase or dim input appears at the outputs after exactly one rising clock edge.
- R11: The mode pin passes through a two-stage synchroniser; a change on it shows at the outputs after the third rising edge following the change, without any reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_pin | input | 1 | Mode pin, 1 = master, 0 = slave (asynchronous) |
| lat_g1 | input | 56 | Segment latch for phase 1 |
| lat_g2 | input | 56 | Segment latch for phase 2 |
| lat_g3 | input | 56 | Segment latch for phase 3 |
| tg_grid | input | 2 | Internal phase code (0 none, 1..3) |
| tg_dim | input | 1 | Internal brightness pulse |
| sync_in1 | input | 1 | External phase code bit 0 (slave) |
| sync_in2 | input | 1 | External phase code bit 1 (slave) |
| dim_in | input | 1 | External brightness pulse (slave) |
| seg_q | output | 56 | Registered segment outputs, 1 = lit |
| grid_n | output | 3 | Active-low grid enables, bit 0 = grid 1 |
| dim_out | output | 1 | Forwarded brightness pulse |
| sync_out1 | output | 1 | Forwarded phase code bit 0 |
| sync_out2 | output | 1 | Forwarded phase code bit 1 |

## Verification
Data, phase and dim changes are due one rising edge after they are applied. Mode changes are due three edges after the pin moves. The bench drives every input on a falling edge and samples on a later falling edge, so a sample never coincides with an active edge. The table walk waits four edges per vector so that both latencies have elapsed. The directed tests then probe the exact due cycles: they sample once before the edge on which a result is due and once after it. For mode changes, they also confirm the old behaviour on the second edge and the new behaviour on the third.

// File: rtl/seg_sel_pkg.sv
package seg_sel_pkg;
  localparam int unsigned PHASES = 3;
  localparam int unsigned CODE_W = $clog2(PHASES + 1);
  typedef logic [CODE_W-1:0] phase_code_t;
  localparam phase_code_t PH_NONE = '0;
endpackage

// File: rtl/seg_mode_sync.sv
module seg_mode_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_a,
  output logic pin_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], pin_a};
  end

  assign pin_s = chain[STAGES-1];
endmodule

// File: rtl/seg_phase_decode.sv
module seg_phase_decode
  import seg_sel_pkg::*;
#(
  parameter int unsigned N_PH = PHASES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master,
  input  phase_code_t     int_code,
  input  logic            int_dim,
  input  logic            ext_s1,
  input  logic            ext_s2,
  input  logic            ext_dim,
  output logic [N_PH-1:0] sel_oh,
  output logic            dim_gate
);
  phase_code_t code;

  assign code     = master ? int_code : phase_code_t'({ext_s2, ext_s1});
  assign dim_gate = master ? int_dim : ext_dim;

  for (genvar k = 0; k < N_PH; k++) begin : g_dec
    assign sel_oh[k] = (code == phase_code_t'(k + 1));
  end

  // R6: the phase decode never selects two latches at once
  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_sel_pkg::*;
#(
  parameter int unsigned SEG_W = 56,
  parameter int unsigned N_PH  = PHASES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       master,
  input  logic [N_PH-1:0][SEG_W-1:0] lats,
  input  logic [N_PH-1:0]            sel_oh,
  input  logic                       dim_gate,
  input  phase_code_t                int_code,
  input  logic                       int_dim,
  output logic [SEG_W-1:0]           seg_q,
  output logic [N_PH-1:0]            grid_n,
  output logic                       dim_out,
  output phase_code_t                sync_out
);
  logic [SEG_W-1:0] seg_d;
  logic [N_PH-1:0]  grid_d;

  always_comb begin
    seg_d = '0;
    for (int k = 0; k < N_PH; k++)
      seg_d |= lats[k] & {SEG_W{sel_oh[k]}};
    seg_d &= {SEG_W{dim_gate}};
  end

  assign grid_d = master ? ~(sel_oh & {N_PH{dim_gate}}) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= '0;
      grid_n   <= '1;
      dim_out  <= 1'b0;
      sync_out <= PH_NONE;
    end else begin
      seg_q    <= seg_d;
      grid_n   <= grid_d;
      dim_out  <= master & int_dim;
      sync_out <= master ? int_code : PH_NONE;
    end
  end

  // R7: a dark brightness pulse darkens every segment on the next cycle
  p_dark_dim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dim_gate |=> (seg_q == '0));
  // R9: no phase selected gives dark segments
  p_no_phase_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oh == '0) |=> (seg_q == '0));
  // R8: slave mode forces grids off and forwarded signals low
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> (grid_n == '1 && !dim_out && sync_out == PH_NONE));
  // R4: at most one grid enable active
  p_grid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grid_n));
  // R5: forwarded brightness follows the internal pulse in master mode
  p_fwd_dim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    master |=> (dim_out == $past(int_dim)));
endmodule

// File: rtl/seg_out_select.sv
module seg_out_select
  import seg_sel_pkg::*;
#(
  parameter int unsigned SEG_W = 56,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ms_pin,
  input  logic [SEG_W-1:0]      lat_g1,
  input  logic [SEG_W-1:0]      lat_g2,
  input  logic [SEG_W-1:0]      lat_g3,
  input  logic [CODE_W-1:0]     tg_grid,
  input  logic                  tg_dim,
  input  logic                  sync_in1,
  input  logic                  sync_in2,
  input  logic                  dim_in,
  output logic [SEG_W-1:0]      seg_q,
  output logic [PHASES-1:0]     grid_n,
  output logic                  dim_out,
  output logic                  sync_out1,
  output logic                  sync_out2
);
  logic                         master_s;
  logic [PHASES-1:0]            sel_oh;
  logic                         dim_gate;
  phase_code_t                  sync_code;
  logic [PHASES-1:0][SEG_W-1:0] lats;

  assign lats = {lat_g3, lat_g2, lat_g1};

  seg_mode_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_msync (
    .clk(clk), .rst_n(rst_n), .pin_a(ms_pin), .pin_s(master_s));

  seg_phase_decode #(.N_PH(PHASES)) u_dec (
    .clk(clk), .rst_n(rst_n), .master(master_s), .int_code(tg_grid),
    .int_dim(tg_dim), .ext_s1(sync_in1), .ext_s2(sync_in2),
    .ext_dim(dim_in), .sel_oh(sel_oh), .dim_gate(dim_gate));

  seg_out_stage #(.SEG_W(SEG_W), .N_PH(PHASES)) u_out (
    .clk(clk), .rst_n(rst_n), .master(master_s), .lats(lats),
    .sel_oh(sel_oh), .dim_gate(dim_gate), .int_code(tg_grid),
    .int_dim(tg_dim), .seg_q(seg_q), .grid_n(grid_n),
    .dim_out(dim_out), .sync_out(sync_code));

  assign sync_out1 = sync_code[0];
  assign sync_out2 = sync_code[1];

  // R2: master mode with the internal pulse low darkens all segments
  p_master_dim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_s && !tg_dim) |=> (seg_q == '0));
endmodule

// File: tb/seg_out_select_tb.sv
module seg_out_select_tb;
  localparam int W = 56;
  localparam logic [W-1:0] P1 = 56'h1111_1111_1111_11;
  localparam logic [W-1:0] P2 = 56'h2222_2222_2222_22;
  localparam logic [W-1:0] P3 = 56'h4444_4444_4444_44;

  typedef struct packed {
    logic       mode;
    logic [1:0] ig;
    logic       idim;
    logic       s1;
    logic       s2;
    logic       edim;
    logic [1:0] elat;
    logic [2:0] egn;
    logic       edo;
    logic [1:0] esync;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 3'b110, 1'b1, 2'd1},
    '{1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 3'b101, 1'b1, 2'd2},
    '{1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 3'b011, 1'b1, 2'd3},
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 3'b111, 1'b0, 2'd3},
    '{1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 3'b111, 1'b1, 2'd0},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 3'b111, 1'b0, 2'd0},
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 3'b111, 1'b0, 2'd0},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 3'b111, 1'b0, 2'd0},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 3'b111, 1'b0, 2'd0},
    '{1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 3'b111, 1'b0, 2'd0},
    '{1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 3'b111, 1'b0, 2'd0},
    '{1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 3'b101, 1'b1, 2'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, ms_pin = 1'b1;
  logic [W-1:0] lat_g1 = P1, lat_g2 = P2, lat_g3 = P3;
  logic [1:0] tg_grid = '0;
  logic tg_dim = 1'b0, sync_in1 = 1'b0, sync_in2 = 1'b0, dim_in = 1'b0;
  logic [W-1:0] seg_q;
  logic [2:0] grid_n;
  logic dim_out, sync_out1, sync_out2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_out_select u_dut (
    .clk(clk), .rst_n(rst_n), .ms_pin(ms_pin), .lat_g1(lat_g1),
    .lat_g2(lat_g2), .lat_g3(lat_g3), .tg_grid(tg_grid), .tg_dim(tg_dim),
    .sync_in1(sync_in1), .sync_in2(sync_in2), .dim_in(dim_in),
    .seg_q(seg_q), .grid_n(grid_n), .dim_out(dim_out),
    .sync_out1(sync_out1), .sync_out2(sync_out2));

  function automatic logic [W-1:0] pick(input logic [1:0] idx);
    case (idx)
      2'd1: return lat_g1;
      2'd2: return lat_g2;
      2'd3: return lat_g3;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply(input vec_t v);
    ms_pin = v.mode; tg_grid = v.ig; tg_dim = v.idim;
    sync_in1 = v.s1; sync_in2 = v.s2; dim_in = v.edim;
  endtask

  initial begin
    // R1: reset state
    edges(3);
    chk("R1 seg", seg_q, '0);
    chk("R1 grid", W'(grid_n), W'(3'b111));
    chk("R1 fwd", W'({dim_out, sync_out2, sync_out1}), '0);
    rst_n = 1'b1;
    edges(1);
    chk("R1 first cycle", W'({seg_q, dim_out, sync_out2, sync_out1}), '0);

    foreach (VECS[i]) begin
      apply(VECS[i]);
      edges(4);
      chk(VECS[i].mode ? "R2 seg" : "R6 seg", seg_q, pick(VECS[i].elat));
      chk(VECS[i].mode ? "R4 grid" : "R8 grid", W'(grid_n), W'(VECS[i].egn));
      chk(VECS[i].mode ? "R5 fwd" : "R8 fwd",
          W'({dim_out, sync_out2, sync_out1}), W'({VECS[i].edo, VECS[i].esync}));
    end

    // R3: master ignores external inputs
    ms_pin = 1; tg_grid = 2'd1; tg_dim = 1; sync_in1 = 0; sync_in2 = 0; dim_in = 0;
    edges(4);
    sync_in1 = 1; sync_in2 = 1; dim_in = 1;
    edges(2);
    chk("R3 seg", seg_q, P1);
    chk("R3 fwd", W'({grid_n, dim_out, sync_out2, sync_out1}), W'({3'b110, 3'b101}));

    // R10: one-edge latency for data and phase
    lat_g1 = ~P1;
    #1 chk("R10 before edge", seg_q, P1);
    edges(1);
    chk("R10 after edge", seg_q, ~P1);
    tg_grid = 2'd3;
    edges(1);
    chk("R10 phase", seg_q, P3);

    // R11: mode change latency of three edges
    sync_in1 = 0; sync_in2 = 1; dim_in = 1;
    ms_pin = 0;
    edges(2);
    chk("R11 edge2 still master", seg_q, P3);
    edges(1);
    chk("R11 edge3 slave", seg_q, P2);
    chk("R11 grid off", W'(grid_n), W'(3'b111));

    // R7: slave dim low darkens
    dim_in = 0;
    edges(1);
    chk("R7 dark", seg_q, '0);
    // R9: slave code 00 darkens with dim high
    dim_in = 1; sync_in2 = 0;
    edges(1);
    chk("R9 none slave", seg_q, '0);
    // R9: master code 0 darkens
    ms_pin = 1; tg_grid = 2'd0; tg_dim = 1;
    edges(4);
    chk("R9 none master", seg_q, '0);
    chk("R9 grids idle", W'(grid_n), W'(3'b111));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule